// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the timer in a local interrupt controller. Software programs it through a small register port. In count mode it loads a starting count and counts down through a programmable prescaler. On expiry it either stops at zero (one-shot) or reloads and continues (periodic). In deadline mode the count is unused. Instead the block compares a free-running 64-bit timestamp input against a programmed deadline and fires once when the timestamp reaches it.

Each expiry is turned into a one-cycle interrupt request that carries an 8-bit vector from the control word, unless the control word masks it. A vector that cannot legally be delivered produces no request. It sets a sticky error bit instead. The mode bits are read only at the moment of expiry. Moving between one-shot and periodic therefore never disturbs a countdown that is in progress. Entering or leaving deadline mode wipes both the count and the deadline. Routing and arbitration of the request happen elsewhere.

Top module: `lvt_timer`

Register map (3-bit word address):

| Address | Register | Access |
|---|---|---|
| 0 | start count | read/write |
| 1 | live count | read-only |
| 2 | divide | read/write |
| 3 | control | read/write |
| 4 | deadline bits 31:0 | read/write |
| 5 | deadline bits 63:32 | read/write |
| 6 | error | read; any write clears |

## Requirements
- R1: A write to the start-count register (address 0) sets both the start count and the live count (address 1) to the written value in the same cycle, with no other effect. The write is ignored while the mode is deadline.
- R2: While the live count is nonzero, it drops by one on every prescaler tick. This happens whatever the mode or mask bits are. A live count of zero does not move.
- R3: In one-shot mode, the tick that takes the live count from 1 to 0 is an expiry. The count then stays at 0. With divide-by-1, the request is visible for exactly one cycle, N clock edges after the write of start count N.
- R4: In periodic mode, an expiry reloads the live count from the start count. Successive requests are therefore N times the prescale ratio cycles apart.
- R5: The mode in the control word (address 3, bits 9:8) is read only at expiry. The codes are: 0 and 3 = one-shot, 1 = periodic, 2 = deadline. Rewriting the mode between one-shot and periodic neither stops nor restarts the running count.
- R6: Writing 0 to the start count disarms the timer. No further expirations happen.
- R7: The divide register keeps bits 3, 1 and 0 and reads bit 2 as zero. The code {bit3, bit1, bit0} selects the prescale ratio: codes 0 to 6 give 2, 4, 8, 16, 32, 64 and 128, and code 7 gives 1. A new code acts on the running count at once.
- R8: Control bit 16 is the mask. An expiry while the mask is set gives no request and no error, but the count and reload still happen.
- R9: An unmasked expiry whose vector (control bits 7:0) is below 16 gives no request. It sets the sticky error bit, which is output on err_flag and readable as bit 0 of address 6. Any write to address 6 clears it. Vector 16 is delivered.
- R10: In deadline mode, the deadline (addresses 4 and 5) expires once the timestamp is at or above a nonzero deadline. The deadline then reads 0. A zero deadline never fires, and nothing fires before the timestamp reaches the deadline.
- R11: A control write that moves the mode into or out of deadline clears the start count, the live count and the deadline.
- R12: After reset: start count, live count, deadline and error read 0. Divide reads 0 (ratio 2). Control reads 0x10000 (masked, one-shot, vector 0). No request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tsc_in | input | 64 | Free-running timestamp |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |
| err_flag | output | 1 | Sticky illegal-vector error |

## Verification
The hardest case to reach from the ports is a change made while a countdown is in flight. Examples are a mode rewrite partway through a count, or a divide switch between reloads. The effect of such a change only shows at later expiries or in the rate of the live count.

The stimulus pins every write to a known clock edge. The scoreboard then predicts exact request cycles across one-shot-to-periodic and periodic-to-one-shot switches. It also measures the spacing of periodic requests after a divide change, and samples the live count over a window just after switching to a slow ratio.

Deadline crossings are reached by arming a count and then moving into deadline mode. Arming a deadline and then leaving the mode covers the other direction.

// File: rtl/lvt_pkg.sv
`timescale 1ns/1ps
package lvt_pkg;
  localparam int DATA_W   = 32;
  localparam int TSC_W    = 2 * DATA_W;
  localparam int VEC_W    = 8;
  localparam int VEC_MIN  = 16;
  localparam int DCODE_W  = 3;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_INIT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CUR   = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DL_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_DL_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_ERR   = 3'd6;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2,
    MODE_RSVD     = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic             mask;
    tmr_mode_e        mode;
    logic [VEC_W-1:0] vector;
  } ctrl_t;

  // divide code -> log2 of prescale ratio; code 7 means ratio 1
  function automatic logic [DCODE_W-1:0] div_shift(input logic [DCODE_W-1:0] code);
    if (code == '1) return '0;
    return code + 1'b1;
  endfunction

  function automatic logic vector_legal(input logic [VEC_W-1:0] v);
    return int'(v) >= VEC_MIN;
  endfunction

  function automatic logic mode_is_deadline(input tmr_mode_e m);
    return m == MODE_DEADLINE;
  endfunction

  function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.vector = w[VEC_W-1:0];
    c.mode   = tmr_mode_e'(w[9:8]);
    c.mask   = w[16];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VEC_W-1:0] = c.vector;
    w[9:8]       = c.mode;
    w[16]        = c.mask;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] div_to_word(input logic [DCODE_W-1:0] code);
    logic [DATA_W-1:0] w;
    w = '0;
    w[3]   = code[2];
    w[1:0] = code[1:0];
    return w;
  endfunction
endpackage

// File: rtl/lvt_prescale.sv
`timescale 1ns/1ps
module lvt_prescale #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] sel_mask;

  // bit i takes part in the tick decode when the ratio exceeds 2**i
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign sel_mask[i] = (shift > SHIFT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // the ratio in use changes the decode at once, not at a later boundary
  assign tick = &(pre_q | ~sel_mask);
endmodule

// File: rtl/lvt_count.sv
`timescale 1ns/1ps
module lvt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             reload_en,
  output logic [CNT_W-1:0] cur_q,
  output logic [CNT_W-1:0] init_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_last;
  assign at_last = (cur_q == ONE);
  assign expire  = tick && at_last && !load_en && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      cur_q  <= '0;
    end else if (clear) begin
      init_q <= '0;
      cur_q  <= '0;
    end else if (load_en) begin
      init_q <= load_val;
      cur_q  <= load_val;
    end else if (tick && cur_q != '0) begin
      if (at_last) cur_q <= reload_en ? init_q : '0;
      else         cur_q <= cur_q - ONE;
    end
  end
endmodule

// File: rtl/lvt_deadline.sv
`timescale 1ns/1ps
module lvt_deadline #(
  parameter int DATA_W = 32,
  parameter int TSC_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [TSC_W-1:0]  tsc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clear,
  output logic [TSC_W-1:0]  dl_q,
  output logic              fire
);
  logic reached;
  assign reached = (dl_q != '0) && (tsc >= dl_q);
  assign fire    = active && reached && !wr_lo && !wr_hi && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n)      dl_q <= '0;
    else if (clear)  dl_q <= '0;
    else if (wr_lo)  dl_q[DATA_W-1:0] <= wdata;
    else if (wr_hi)  dl_q[TSC_W-1:DATA_W] <= wdata[TSC_W-DATA_W-1:0];
    else if (fire)   dl_q <= '0;
  end
endmodule

// File: rtl/lvt_timer.sv
`timescale 1ns/1ps
module lvt_timer
  import lvt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [63:0]       tsc_in,
  output logic              irq_valid,
  output logic [7:0]        irq_vector,
  output logic              err_flag
);
  ctrl_t               ctrl_q;
  ctrl_t               ctrl_new;
  logic [DCODE_W-1:0]  div_code_q;
  logic [DCODE_W-1:0]  shift;
  logic                tick;
  logic                in_dl;
  logic                wr_init, wr_div, wr_ctrl, wr_lo, wr_hi, wr_err;
  logic                mode_cross;
  logic                is_periodic;
  logic                mask_bit;
  logic [CNT_W-1:0]    cur_cnt, init_cnt;
  logic                cnt_expire;
  logic [TSC_W-1:0]    dl_q;
  logic                dl_fire;
  logic                expire_any, deliver, bad_vec;
  logic                irq_valid_q, err_q;
  logic [VEC_W-1:0]    irq_vec_q;

  // register decode
  assign in_dl    = mode_is_deadline(ctrl_q.mode);
  assign wr_init  = reg_wr && reg_addr == A_INIT && !in_dl;
  assign wr_div   = reg_wr && reg_addr == A_DIV;
  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  assign wr_lo    = reg_wr && reg_addr == A_DL_LO;
  assign wr_hi    = reg_wr && reg_addr == A_DL_HI;
  assign wr_err   = reg_wr && reg_addr == A_ERR;
  assign ctrl_new = ctrl_from_word(reg_wdata);
  assign mode_cross = wr_ctrl &&
                      (mode_is_deadline(ctrl_q.mode) != mode_is_deadline(ctrl_new.mode));
  assign is_periodic = (ctrl_q.mode == MODE_PERIODIC);
  assign mask_bit    = ctrl_q.mask;
  assign shift       = div_shift(div_code_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '{mask: 1'b1, mode: MODE_ONESHOT, vector: '0};
      div_code_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_div)  div_code_q <= {reg_wdata[3], reg_wdata[1:0]};
    end
  end

  lvt_prescale #(.SHIFT_W(DCODE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (shift),
    .tick  (tick)
  );

  lvt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load_en   (wr_init),
    .load_val  (reg_wdata[CNT_W-1:0]),
    .clear     (mode_cross),
    .reload_en (is_periodic),
    .cur_q     (cur_cnt),
    .init_q    (init_cnt),
    .expire    (cnt_expire)
  );

  lvt_deadline #(.DATA_W(DATA_W), .TSC_W(TSC_W)) u_dl (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (in_dl),
    .tsc    (tsc_in),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wdata  (reg_wdata),
    .clear  (mode_cross),
    .dl_q   (dl_q),
    .fire   (dl_fire)
  );

  // expiry handling: mask and vector legality are consulted only here
  assign expire_any = cnt_expire || dl_fire;
  assign deliver    = expire_any && !ctrl_q.mask && vector_legal(ctrl_q.vector);
  assign bad_vec    = expire_any && !ctrl_q.mask && !vector_legal(ctrl_q.vector);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid_q <= 1'b0;
      irq_vec_q   <= '0;
      err_q       <= 1'b0;
    end else begin
      irq_valid_q <= deliver;
      if (deliver) irq_vec_q <= ctrl_q.vector;
      if (bad_vec)     err_q <= 1'b1;
      else if (wr_err) err_q <= 1'b0;
    end
  end

  assign irq_valid  = irq_valid_q;
  assign irq_vector = irq_vec_q;
  assign err_flag   = err_q;

  always_comb begin
    unique case (reg_addr)
      A_INIT:  reg_rdata = DATA_W'(init_cnt);
      A_CUR:   reg_rdata = DATA_W'(cur_cnt);
      A_DIV:   reg_rdata = div_to_word(div_code_q);
      A_CTRL:  reg_rdata = ctrl_to_word(ctrl_q);
      A_DL_LO: reg_rdata = dl_q[DATA_W-1:0];
      A_DL_HI: reg_rdata = dl_q[TSC_W-1:DATA_W];
      A_ERR:   reg_rdata = {{(DATA_W-1){1'b0}}, err_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lvt_timer_chk.sv
`timescale 1ns/1ps
module lvt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic [7:0]       irq_vector,
  input logic             err_flag,
  input logic             cnt_expire,
  input logic             dl_fire,
  input logic             mode_cross,
  input logic             wr_init,
  input logic             wr_err,
  input logic [CNT_W-1:0] cur_cnt,
  input logic [CNT_W-1:0] init_cnt,
  input logic [63:0]      dl_q,
  input logic             is_periodic,
  input logic             mask_bit
);
  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(cnt_expire || dl_fire));

  // R9
  irq_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector >= 8'd16);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !wr_err |=> err_flag);

  // R3
  oneshot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_expire && !is_periodic |=> cur_cnt == '0);

  // R4
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_expire && is_periodic |=> cur_cnt == $past(init_cnt));

  // R11
  mode_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cross |=> (cur_cnt == '0 && init_cnt == '0 && dl_q == '0));

  // R10
  dl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_fire |=> dl_q == '0);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_init && !mode_cross && !cnt_expire |=>
      (cur_cnt == $past(cur_cnt) || cur_cnt == $past(cur_cnt) - CNT_W'(1)));

  // R8
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask_bit));
endmodule

bind lvt_timer lvt_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_lvt_timer.sv
`timescale 1ns/1ps
module sim_lvt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] tsc = '0;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic        err_flag;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int last_e = 0;
  int irq_cnt = 0;
  int irq_times[$];

  typedef struct { string req; int vec; int at; } exp_t;
  exp_t expq[$];

  lvt_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tsc_in(tsc),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .err_flag(err_flag)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tsc <= tsc + 64'd1;

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_irq(input string req, input int vec, input int at);
    exp_t e;
    e.req = req; e.vec = vec; e.at = at;
    expq.push_back(e);
  endtask

  // monitor: pops expected requests as the design produces them
  always @(negedge clk) begin
    if (rst_n && irq_valid) begin
      exp_t e;
      irq_cnt++;
      irq_times.push_back(cyc);
      if (expq.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL unexpected request actual=vector %0d at %0d expected=none", irq_vector, cyc);
      end else begin
        e = expq.pop_front();
        check(e.req, irq_vector, e.vec);
        if (e.at >= 0) check(e.req, cyc, e.at);
      end
    end
  end

  // called at a falling edge; the write lands on the next rising edge (last_e)
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 last_e = cyc;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    #(20 * 180000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, c0, c1;
    int e;
    longint tnow;
    int n0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd_now(3'd0, v); check("R12 init", v, 0);
    rd_now(3'd1, v); check("R12 cur", v, 0);
    rd_now(3'd2, v); check("R12 div", v, 0);
    rd_now(3'd3, v); check("R12 ctrl", v, 32'h10000);
    rd_now(3'd6, v); check("R12 err", v, 0);
    check("R12 irq", irq_valid, 0);

    // R7 readback: bit 2 not kept
    wr(3'd2, 32'hF); rd_now(3'd2, v); check("R7 div bits", v, 32'hB);

    // R3 one-shot, R1 load
    wr(3'd3, 32'h40);
    wr(3'd0, 5); e = last_e;
    push_irq("R3 oneshot", 8'h40, e + 5);
    rd_now(3'd1, v); check("R1 cur loaded", v, 5);
    wait_until(e + 25);
    rd_now(3'd1, v); check("R3 stays zero", v, 0);
    check("R3 single pulse", expq.size(), 0);

    // R4 periodic, R6 disarm
    wr(3'd3, 32'h141);
    wr(3'd0, 6); e = last_e;
    push_irq("R4 periodic", 8'h41, e + 6);
    push_irq("R4 periodic", 8'h41, e + 12);
    push_irq("R4 periodic", 8'h41, e + 18);
    wait_until(e + 20);
    wr(3'd0, 0);
    repeat (30) @(negedge clk);
    check("R6 disarm queue", expq.size(), 0);
    rd_now(3'd1, v); check("R6 cur zero", v, 0);

    // R5 mode switch mid-count
    wr(3'd3, 32'h42);
    wr(3'd0, 10); e = last_e;
    wr(3'd3, 32'h142);
    rd_now(3'd1, v); check("R5 no restart", v, 9);
    rd_now(3'd0, v); check("R1 init value", v, 10);
    push_irq("R5 to periodic", 8'h42, e + 10);
    push_irq("R5 to periodic", 8'h42, e + 20);
    push_irq("R5 back to oneshot", 8'h42, e + 30);
    wait_until(e + 22);
    wr(3'd3, 32'h042);
    wait_until(e + 45);
    rd_now(3'd1, v); check("R5 oneshot stop", v, 0);
    check("R5 queue", expq.size(), 0);

    // R8 mask keeps counting and reloading
    wr(3'd3, 32'h10143);
    wr(3'd0, 4); e = last_e;
    wait_until(e + 4);
    rd_now(3'd1, v); check("R8 reload while masked", v, 4);
    wait_until(e + 6);
    rd_now(3'd1, v); check("R8 count while masked", v, 2);
    wr(3'd3, 32'h143);
    push_irq("R8 unmasked", 8'h43, e + 8);
    push_irq("R8 unmasked", 8'h43, e + 12);
    wait_until(e + 13);
    wr(3'd0, 0);
    check("R8 queue", expq.size(), 0);

    // R9 illegal vector
    wr(3'd3, 32'h00F);
    wr(3'd0, 3); e = last_e;
    wait_until(e + 3);
    rd_now(3'd6, v); check("R9 err reg", v, 1);
    check("R9 err flag", err_flag, 1);
    wr(3'd6, 0);
    rd_now(3'd6, v); check("R9 err cleared", v, 0);
    wr(3'd3, 32'h010);
    wr(3'd0, 3); e = last_e;
    push_irq("R9 vector 16 legal", 8'h10, e + 3);
    wait_until(e + 5);
    check("R9 no err for 16", err_flag, 0);

    // R7 ratio 4 spacing
    wr(3'd3, 32'h144);
    wr(3'd0, 4);
    irq_times.delete();
    wr(3'd2, 32'h1);
    for (int i = 0; i < 4; i++) push_irq("R7 ratio 4", 8'h44, -1);
    while (irq_times.size() < 4) @(negedge clk);
    wr(3'd0, 0);
    check("R7 spacing", irq_times[3] - irq_times[2], 16);
    check("R7 spacing", irq_times[2] - irq_times[1], 16);

    // R7 immediate effect of a slow ratio
    wr(3'd3, 32'h044);
    wr(3'd2, 32'hB);
    wr(3'd0, 1000);
    wr(3'd2, 32'hA); e = last_e;
    rd_now(3'd1, c0);
    wait_until(e + 40);
    rd_now(3'd1, c1);
    check("R7 immediate", (c0 >= c1 && c0 - c1 <= 1), 1);
    wr(3'd0, 0);
    wr(3'd2, 32'hB);

    // R11 entering deadline clears count
    wr(3'd3, 32'h045);
    wr(3'd0, 100);
    wr(3'd3, 32'h245);
    rd_now(3'd0, v); check("R11 init cleared", v, 0);
    rd_now(3'd1, v); check("R11 cur cleared", v, 0);
    wr(3'd0, 7);
    rd_now(3'd0, v); check("R1 ignored in deadline", v, 0);

    // R10 deadline in the future
    tnow = longint'(tsc);
    wr(3'd5, 0);
    wr(3'd4, 32'(tnow + 30));
    push_irq("R10 deadline", 8'h45, -1);
    n0 = irq_cnt;
    repeat (10) @(negedge clk);
    check("R10 not early", irq_cnt, n0);
    while (irq_cnt == n0) @(negedge clk);
    rd_now(3'd4, v); check("R10 deadline cleared", v, 0);
    repeat (10) @(negedge clk);
    check("R10 once", irq_cnt, n0 + 1);

    // R10 deadline already passed fires at once
    wr(3'd4, 5);
    push_irq("R10 past deadline", 8'h45, -1);
    n0 = irq_cnt;
    repeat (3) @(negedge clk);
    check("R10 past fires", irq_cnt, n0 + 1);

    // R11 leaving deadline clears deadline
    wr(3'd5, 1);
    wr(3'd3, 32'h045);
    rd_now(3'd5, v); check("R11 deadline cleared", v, 0);

    repeat (20) @(negedge clk);
    check("R10 final queue", expq.size(), 0);
    summary();
    $finish;
  end
endmodule